// File: doc/BRIEF.md
# DMA Request Execution Sequencer

This block takes one decoded transfer request at a time and carries it through a fixed series of phases. A request holds a command byte, addresses, a 32-bit byte count, doorbell settings and a small array of semaphore commands. The sequencer first runs the one semaphore command that gates the transfer, if the request has one. It then waits on any fences that the request asks for. Next it starts the transfer on a DMA engine, which is modelled only as a start/done pair, and after that it works through the remaining semaphore commands in slot order. Last it rings the doorbell, and it finishes by pushing a response entry and pulsing an interrupt when either is called for.

The command byte picks the direction, picks bulk or linked-list mode, asks for a response and can force an interrupt. A request with an illegal direction code, or with more than one gating semaphore command, is not executed at all. Instead it ends at once with an error response. The semaphore unit and the doorbell writer each use a request line that stays high until that unit's acknowledge. The block holds only one request at a time.

Top module: `dma_req_seq`

## Requirements
- R1: The direction field is command bits [1:0]. Code 1 (host to device) and code 2 (device to host) each cause exactly one `dma_start` pulse, with `dma_dir` equal to the code. Code 0 issues no start, and the postsync phase follows straight after the fence phase.
- R2: Direction code 3 is illegal. Such a request issues no semaphore operation, no start and no doorbell write. It ends with a response that has `rsp_err`=1 and the request's ID, whether or not command bit 4 is set.
- R3: Command bit 3 drives `dma_bulk` (1 means bulk, 0 means linked list). `dma_src` carries the source field, which is the list address in linked-list mode. `dma_dst` and the full 32-bit `dma_len`, up to 0xFFFFFFFF, pass through unchanged.
- R4: With command bit 4 set, completion gives exactly one `rsp_valid` pulse with `rsp_id` equal to the request ID and `rsp_err`=0. A request with bit 4 clear that has no error gives no response.
- R5: Command bit 7 raises a single `irq` pulse in the completion cycle, but only while `force_irq_en` is 1. When a response is also due, the pulse falls in the same cycle as `rsp_valid`.
- R6: A semaphore word with bit 31 (enable) and bit 22 (presync) both set is issued before the transfer starts. A request with two or more such words is rejected with an error response, as in R2.
- R7: Enabled words with bit 22 clear are issued after the transfer is done, in ascending slot order. The operation is bits [26:24], the index is bits [20:16] and the value is bits [11:0]. A word whose operation is 0 (no-op) or 7 (reserved) is never issued, and neither is a word with bit 31 clear.
- R8: Bit 30 (host-to-device fence) or bit 29 (device-to-host fence) in any enabled word holds the request before its transfer for as long as `h2d_busy` or `d2h_busy` respectively is high. A busy line for a fence that was not requested causes no delay.
- R9: Doorbell attribute bit 7 enables the doorbell write. Attribute bits [1:0] set the width (0 is 32-bit, 1 is 16-bit, 2 is 8-bit), and `db_data` keeps only that many low bits. Code 3 suppresses the write. The write comes after all postsync operations and before the response.
- R10: The sequence ID is passed to `rsp_seq` and has no effect on which operations are issued.
- R11: `req_ready` is 1 after reset and falls for the whole time a request is in flight. At most one of `sem_req`, `dma_start`, `db_req` and `rsp_valid` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| force_irq_en | input | 1 | Enables command bit 7 to force an interrupt |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| req_id | input | ID_W | Request ID |
| req_seq | input | ID_W | Sequence ID, carried only |
| req_cmd | input | 8 | Command byte |
| req_src | input | ADDR_W | Source address or list address |
| req_dst | input | ADDR_W | Destination address |
| req_len | input | LEN_W | Transfer byte count |
| req_db_addr | input | ADDR_W | Doorbell address |
| req_db_attr | input | 8 | Doorbell enable and width code |
| req_db_data | input | 32 | Doorbell data |
| req_sem | input | N_SEM*32 | Semaphore command words, slot 0 in the low bits |
| h2d_busy | input | 1 | Host-to-device transfers are still outstanding |
| d2h_busy | input | 1 | Device-to-host transfers are still outstanding |
| sem_req | output | 1 | Semaphore operation request |
| sem_ack | input | 1 | Semaphore operation finished |
| sem_op | output | 3 | Semaphore operation code |
| sem_idx | output | 5 | Semaphore index |
| sem_val | output | 12 | Semaphore operand |
| dma_start | output | 1 | One-cycle start pulse for the engine |
| dma_done | input | 1 | Engine finished the transfer |
| dma_dir | output | 2 | Transfer direction code |
| dma_bulk | output | 1 | 1 for bulk, 0 for linked list |
| dma_src | output | ADDR_W | Source or list address |
| dma_dst | output | ADDR_W | Destination address |
| dma_len | output | LEN_W | Byte count |
| db_req | output | 1 | Doorbell write request |
| db_ack | input | 1 | Doorbell write finished |
| db_addr | output | ADDR_W | Doorbell address |
| db_width | output | 2 | Doorbell width code |
| db_data | output | 32 | Doorbell data, masked to width |
| rsp_valid | output | 1 | Response push, one cycle |
| rsp_id | output | ID_W | Response request ID |
| rsp_seq | output | ID_W | Response sequence ID |
| rsp_err | output | 1 | Request rejected |
| irq | output | 1 | Forced interrupt pulse |

## Verification
Two things can happen in the completion cycle: the response push and the forced interrupt. The bench sends a request with both command bit 4 and bit 7 set while `force_irq_en` is high. It judges the result by the interrupt being seen in the very cycle in which the response carries the right ID. A second request keeps bit 7 but clears the enable, and this must give no interrupt. A related check concerns the end of the fence wait, where a gated request must not start its transfer in a cycle in which a requested busy line is still high. The bench holds `h2d_busy` high over many cycles and looks for no start and a low `req_ready`. It also holds the unrequested busy line high, which must not delay the request.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam int CMD_W  = 8;
  localparam int SEMW_W = 32;
  localparam int DB_W   = 32;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CHECK, ST_PRE, ST_FENCE, ST_DMA_GO,
    ST_DMA_WAIT, ST_POST, ST_DB, ST_DONE
  } seq_state_e;

  // command byte fields
  function automatic logic [1:0] cmd_dir(input logic [CMD_W-1:0] c);
    return c[1:0];
  endfunction
  function automatic logic cmd_bulk(input logic [CMD_W-1:0] c);
    return c[3];
  endfunction
  function automatic logic cmd_want_rsp(input logic [CMD_W-1:0] c);
    return c[4];
  endfunction
  function automatic logic cmd_force_irq(input logic [CMD_W-1:0] c);
    return c[7];
  endfunction

  // semaphore word fields
  function automatic logic sem_on(input logic [SEMW_W-1:0] w);
    return w[31];
  endfunction
  function automatic logic sem_fence_h2d(input logic [SEMW_W-1:0] w);
    return w[30];
  endfunction
  function automatic logic sem_fence_d2h(input logic [SEMW_W-1:0] w);
    return w[29];
  endfunction
  function automatic logic [2:0] sem_opcode(input logic [SEMW_W-1:0] w);
    return w[26:24];
  endfunction
  function automatic logic sem_is_pre(input logic [SEMW_W-1:0] w);
    return w[22];
  endfunction
  function automatic logic [4:0] sem_index(input logic [SEMW_W-1:0] w);
    return w[20:16];
  endfunction
  function automatic logic [11:0] sem_operand(input logic [SEMW_W-1:0] w);
    return w[11:0];
  endfunction
  // op codes 1..6 do work; 0 is no-op, 7 reserved
  function automatic logic sem_op_real(input logic [SEMW_W-1:0] w);
    return (sem_opcode(w) != 3'd0) && (sem_opcode(w) != 3'd7);
  endfunction

  // doorbell attribute fields
  function automatic logic db_enabled(input logic [7:0] a);
    return a[7] && (a[1:0] != 2'd3);
  endfunction
  function automatic logic [DB_W-1:0] db_mask(input logic [DB_W-1:0] d,
                                               input logic [1:0] code);
    case (code)
      2'd1:    return {16'h0, d[15:0]};
      2'd2:    return {24'h0, d[7:0]};
      default: return d;
    endcase
  endfunction

endpackage

// File: rtl/dma_seq_hold.sv
module dma_seq_hold #(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32,
  parameter int ID_W   = 16,
  parameter int N_SEM  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [ID_W-1:0]               in_id,
  input  logic [ID_W-1:0]               in_seq,
  input  logic [7:0]                    in_cmd,
  input  logic [ADDR_W-1:0]             in_src,
  input  logic [ADDR_W-1:0]             in_dst,
  input  logic [LEN_W-1:0]              in_len,
  input  logic [ADDR_W-1:0]             in_db_addr,
  input  logic [7:0]                    in_db_attr,
  input  logic [31:0]                   in_db_data,
  input  logic [N_SEM-1:0][31:0]        in_sem,
  output logic [ID_W-1:0]               q_id,
  output logic [ID_W-1:0]               q_seq,
  output logic [7:0]                    q_cmd,
  output logic [ADDR_W-1:0]             q_src,
  output logic [ADDR_W-1:0]             q_dst,
  output logic [LEN_W-1:0]              q_len,
  output logic [ADDR_W-1:0]             q_db_addr,
  output logic [7:0]                    q_db_attr,
  output logic [31:0]                   q_db_data,
  output logic [N_SEM-1:0][31:0]        q_sem
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_id      <= '0;
      q_seq     <= '0;
      q_cmd     <= '0;
      q_src     <= '0;
      q_dst     <= '0;
      q_len     <= '0;
      q_db_addr <= '0;
      q_db_attr <= '0;
      q_db_data <= '0;
      q_sem     <= '0;
    end else if (load) begin
      q_id      <= in_id;
      q_seq     <= in_seq;
      q_cmd     <= in_cmd;
      q_src     <= in_src;
      q_dst     <= in_dst;
      q_len     <= in_len;
      q_db_addr <= in_db_addr;
      q_db_attr <= in_db_attr;
      q_db_data <= in_db_data;
      q_sem     <= in_sem;
    end
  end
endmodule

// File: rtl/dma_seq_decode.sv
module dma_seq_decode
  import dma_seq_pkg::*;
#(
  parameter int N_SEM = 4,
  localparam int PTR_W = (N_SEM > 1) ? $clog2(N_SEM) : 1
) (
  input  logic [7:0]             cmd,
  input  logic [N_SEM-1:0][31:0] sem,
  output logic                   dir_none,
  output logic                   bad,
  output logic                   pre_do,
  output logic [PTR_W-1:0]       pre_sel,
  output logic                   need_h2d,
  output logic                   need_d2h,
  output logic [N_SEM-1:0]       post_mask
);
  logic [PTR_W:0] pre_cnt;
  logic           pre_real;

  always_comb begin
    pre_cnt   = '0;
    pre_sel   = '0;
    pre_real  = 1'b0;
    need_h2d  = 1'b0;
    need_d2h  = 1'b0;
    post_mask = '0;
    for (int i = 0; i < N_SEM; i++) begin
      if (sem_on(sem[i])) begin
        need_h2d = need_h2d | sem_fence_h2d(sem[i]);
        need_d2h = need_d2h | sem_fence_d2h(sem[i]);
        if (sem_is_pre(sem[i])) begin
          pre_cnt  = pre_cnt + 1'b1;
          pre_sel  = PTR_W'(i);
          pre_real = sem_op_real(sem[i]);
        end else if (sem_op_real(sem[i])) begin
          post_mask[i] = 1'b1;
        end
      end
    end
  end

  assign dir_none = (cmd_dir(cmd) == 2'd0);
  assign bad      = (cmd_dir(cmd) == 2'd3) || (pre_cnt > 1);
  assign pre_do   = (pre_cnt == 1) && pre_real;
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
#(
  parameter int N_SEM = 4,
  localparam int PTR_W = (N_SEM > 1) ? $clog2(N_SEM) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             bad,
  input  logic             dir_none,
  input  logic             pre_do,
  input  logic             need_h2d,
  input  logic             need_d2h,
  input  logic [N_SEM-1:0] post_mask,
  input  logic             h2d_busy,
  input  logic             d2h_busy,
  input  logic             sem_ack,
  input  logic             dma_done,
  input  logic             db_go,
  input  logic             db_ack,
  output seq_state_e       state,
  output logic [PTR_W-1:0] ptr,
  output logic             load,
  output logic             sem_req,
  output logic             dma_start,
  output logic             db_req,
  output logic             done
);
  seq_state_e       nstate;
  logic [PTR_W-1:0] nptr;
  logic             fence_clear;
  logic             post_adv;
  logic             post_last;

  assign fence_clear = !(need_h2d && h2d_busy) && !(need_d2h && d2h_busy);
  assign post_adv    = !post_mask[ptr] || sem_ack;
  assign post_last   = (ptr == PTR_W'(N_SEM - 1));

  always_comb begin
    nstate = state;
    nptr   = ptr;
    case (state)
      ST_IDLE:     if (req_valid) nstate = ST_CHECK;
      ST_CHECK: begin
        nptr   = '0;
        nstate = bad ? ST_DONE : ST_PRE;
      end
      ST_PRE:      if (!pre_do || sem_ack) nstate = ST_FENCE;
      ST_FENCE:    if (fence_clear) nstate = dir_none ? ST_POST : ST_DMA_GO;
      ST_DMA_GO:   nstate = ST_DMA_WAIT;
      ST_DMA_WAIT: if (dma_done) nstate = ST_POST;
      ST_POST: begin
        if (post_adv) begin
          if (post_last) nstate = ST_DB;
          else           nptr   = ptr + 1'b1;
        end
      end
      ST_DB:       if (!db_go || db_ack) nstate = ST_DONE;
      ST_DONE:     nstate = ST_IDLE;
      default:     nstate = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ptr   <= '0;
    end else begin
      state <= nstate;
      ptr   <= nptr;
    end
  end

  assign load      = (state == ST_IDLE) && req_valid;
  assign sem_req   = ((state == ST_PRE) && pre_do) ||
                     ((state == ST_POST) && post_mask[ptr]);
  assign dma_start = (state == ST_DMA_GO);
  assign db_req    = (state == ST_DB) && db_go;
  assign done      = (state == ST_DONE);
endmodule

// File: rtl/dma_req_seq.sv
module dma_req_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32,
  parameter int ID_W   = 16,
  parameter int N_SEM  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  force_irq_en,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ID_W-1:0]       req_id,
  input  logic [ID_W-1:0]       req_seq,
  input  logic [7:0]            req_cmd,
  input  logic [ADDR_W-1:0]     req_src,
  input  logic [ADDR_W-1:0]     req_dst,
  input  logic [LEN_W-1:0]      req_len,
  input  logic [ADDR_W-1:0]     req_db_addr,
  input  logic [7:0]            req_db_attr,
  input  logic [31:0]           req_db_data,
  input  logic [N_SEM*32-1:0]   req_sem,
  input  logic                  h2d_busy,
  input  logic                  d2h_busy,
  output logic                  sem_req,
  input  logic                  sem_ack,
  output logic [2:0]            sem_op,
  output logic [4:0]            sem_idx,
  output logic [11:0]           sem_val,
  output logic                  dma_start,
  input  logic                  dma_done,
  output logic [1:0]            dma_dir,
  output logic                  dma_bulk,
  output logic [ADDR_W-1:0]     dma_src,
  output logic [ADDR_W-1:0]     dma_dst,
  output logic [LEN_W-1:0]      dma_len,
  output logic                  db_req,
  input  logic                  db_ack,
  output logic [ADDR_W-1:0]     db_addr,
  output logic [1:0]            db_width,
  output logic [31:0]           db_data,
  output logic                  rsp_valid,
  output logic [ID_W-1:0]       rsp_id,
  output logic [ID_W-1:0]       rsp_seq,
  output logic                  rsp_err,
  output logic                  irq
);
  localparam int PTR_W = (N_SEM > 1) ? $clog2(N_SEM) : 1;

  logic [N_SEM-1:0][31:0] sem_in;
  logic [N_SEM-1:0][31:0] sem_q;
  logic [ID_W-1:0]        id_q, seq_q;
  logic [7:0]             cmd_q, attr_q;
  logic [ADDR_W-1:0]      src_q, dst_q, dba_q;
  logic [LEN_W-1:0]       len_q;
  logic [31:0]            dbd_q;

  logic                   dir_none, bad, pre_do, need_h2d, need_d2h;
  logic [PTR_W-1:0]       pre_sel, ptr, sem_sel;
  logic [N_SEM-1:0]       post_mask;
  seq_state_e             state;
  logic                   load, done, db_go;
  logic [31:0]            sem_word;

  // named internal events, used by the checker
  logic                   evt_accept;
  logic                   evt_complete;

  assign sem_in = req_sem;

  dma_seq_hold #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .ID_W(ID_W), .N_SEM(N_SEM)
  ) hold_i (
    .clk(clk), .rst_n(rst_n), .load(load),
    .in_id(req_id), .in_seq(req_seq), .in_cmd(req_cmd),
    .in_src(req_src), .in_dst(req_dst), .in_len(req_len),
    .in_db_addr(req_db_addr), .in_db_attr(req_db_attr),
    .in_db_data(req_db_data), .in_sem(sem_in),
    .q_id(id_q), .q_seq(seq_q), .q_cmd(cmd_q),
    .q_src(src_q), .q_dst(dst_q), .q_len(len_q),
    .q_db_addr(dba_q), .q_db_attr(attr_q), .q_db_data(dbd_q),
    .q_sem(sem_q)
  );

  dma_seq_decode #(.N_SEM(N_SEM)) dec_i (
    .cmd(cmd_q), .sem(sem_q),
    .dir_none(dir_none), .bad(bad), .pre_do(pre_do), .pre_sel(pre_sel),
    .need_h2d(need_h2d), .need_d2h(need_d2h), .post_mask(post_mask)
  );

  assign db_go = db_enabled(attr_q);

  dma_seq_ctrl #(.N_SEM(N_SEM)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .bad(bad), .dir_none(dir_none), .pre_do(pre_do),
    .need_h2d(need_h2d), .need_d2h(need_d2h), .post_mask(post_mask),
    .h2d_busy(h2d_busy), .d2h_busy(d2h_busy),
    .sem_ack(sem_ack), .dma_done(dma_done), .db_go(db_go), .db_ack(db_ack),
    .state(state), .ptr(ptr), .load(load),
    .sem_req(sem_req), .dma_start(dma_start), .db_req(db_req), .done(done)
  );

  assign evt_accept   = load;
  assign evt_complete = done;
  assign req_ready    = (state == ST_IDLE);

  assign sem_sel  = (state == ST_PRE) ? pre_sel : ptr;
  assign sem_word = sem_q[sem_sel];
  assign sem_op   = sem_opcode(sem_word);
  assign sem_idx  = sem_index(sem_word);
  assign sem_val  = sem_operand(sem_word);

  assign dma_dir  = cmd_dir(cmd_q);
  assign dma_bulk = cmd_bulk(cmd_q);
  assign dma_src  = src_q;
  assign dma_dst  = dst_q;
  assign dma_len  = len_q;

  assign db_addr  = dba_q;
  assign db_width = attr_q[1:0];
  assign db_data  = db_mask(dbd_q, attr_q[1:0]);

  assign rsp_valid = done && (cmd_want_rsp(cmd_q) || bad);
  assign rsp_err   = done && bad;
  assign rsp_id    = id_q;
  assign rsp_seq   = seq_q;
  assign irq       = done && cmd_force_irq(cmd_q) && force_irq_en;
endmodule

// File: rtl/dma_req_seq_chk.sv
module dma_req_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       force_irq_en,
  input logic       req_ready,
  input logic       sem_req,
  input logic       dma_start,
  input logic [1:0] dma_dir,
  input logic       db_req,
  input logic       db_ack,
  input logic [31:0] db_data,
  input logic       rsp_valid,
  input logic       rsp_err,
  input logic       irq,
  input logic       evt_accept,
  input logic       evt_complete
);
  logic started;

  always_ff @(posedge clk) begin
    if (!rst_n)          started <= 1'b0;
    else if (evt_accept) started <= 1'b0;
    else if (dma_start)  started <= 1'b1;
  end

  AST_DIR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |-> (dma_dir == 2'd1 || dma_dir == 2'd2)); // R1

  AST_ERR_NO_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> !started); // R2

  AST_RSP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> evt_complete); // R4

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (force_irq_en && evt_complete)); // R5

  AST_DB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (db_req && !db_ack) |=> (db_req && $stable(db_data))); // R9

  AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sem_req, dma_start, db_req, rsp_valid})); // R11

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> !req_ready); // R11
endmodule

bind dma_req_seq dma_req_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .force_irq_en(force_irq_en),
  .req_ready(req_ready), .sem_req(sem_req), .dma_start(dma_start),
  .dma_dir(dma_dir), .db_req(db_req), .db_ack(db_ack), .db_data(db_data),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .irq(irq),
  .evt_accept(evt_accept), .evt_complete(evt_complete)
);

// File: tb/dma_req_seq_tb_top.sv
module dma_req_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 64, LW = 32, IW = 16, NS = 4;
  localparam int K_SEM = 1, K_DMA = 2, K_DB = 3, K_RSP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic force_irq_en = 1'b0, req_valid = 1'b0, req_ready;
  logic [IW-1:0] req_id = '0, req_seq = '0;
  logic [7:0] req_cmd = '0, req_db_attr = '0;
  logic [AW-1:0] req_src = '0, req_dst = '0, req_db_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [31:0] req_db_data = '0;
  logic [NS*32-1:0] req_sem = '0;
  logic h2d_busy = 1'b0, d2h_busy = 1'b0;
  logic sem_req, sem_ack = 1'b0, dma_start, dma_done = 1'b0;
  logic db_req, db_ack = 1'b0;
  logic [2:0] sem_op; logic [4:0] sem_idx; logic [11:0] sem_val;
  logic [1:0] dma_dir, db_width; logic dma_bulk;
  logic [AW-1:0] dma_src, dma_dst, db_addr;
  logic [LW-1:0] dma_len; logic [31:0] db_data;
  logic rsp_valid, rsp_err, irq;
  logic [IW-1:0] rsp_id, rsp_seq;

  int total = 0, bad = 0;
  int n_ev = 0, irq_cnt = 0, sem_cnt = 0, dma_cnt = 0, db_cnt = 0;
  int ev_kind [32];
  logic [63:0] ev_a [32];
  logic [63:0] ev_b [32];
  logic [63:0] last_dst, last_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_req_seq #(.ADDR_W(AW), .LEN_W(LW), .ID_W(IW), .N_SEM(NS)) dut_i (.*);

  // semaphore unit model
  always @(negedge clk) begin
    if (!rst_n) begin sem_ack = 1'b0; sem_cnt = 0; end
    else if (sem_ack) sem_ack = 1'b0;
    else if (sem_req) begin
      if (sem_cnt >= 2) begin
        sem_ack = 1'b1; sem_cnt = 0;
        if (n_ev < 32) begin
          ev_kind[n_ev] = K_SEM; ev_a[n_ev] = 64'({sem_op, sem_idx, sem_val});
          ev_b[n_ev] = 0; n_ev++;
        end
      end else sem_cnt++;
    end
  end

  // DMA engine model
  always @(negedge clk) begin
    if (!rst_n) begin dma_done = 1'b0; dma_cnt = 0; end
    else begin
      if (dma_done) dma_done = 1'b0;
      if (dma_start) begin
        if (n_ev < 32) begin
          ev_kind[n_ev] = K_DMA; ev_a[n_ev] = 64'({dma_dir, dma_bulk});
          ev_b[n_ev] = dma_src; n_ev++;
        end
        last_dst = dma_dst; last_len = 64'(dma_len); dma_cnt = 3;
      end else if (dma_cnt > 0) begin
        dma_cnt--;
        if (dma_cnt == 0) dma_done = 1'b1;
      end
    end
  end

  // doorbell writer model
  always @(negedge clk) begin
    if (!rst_n) begin db_ack = 1'b0; db_cnt = 0; end
    else if (db_ack) db_ack = 1'b0;
    else if (db_req) begin
      if (db_cnt >= 1) begin
        db_ack = 1'b1; db_cnt = 0;
        if (n_ev < 32) begin
          ev_kind[n_ev] = K_DB; ev_a[n_ev] = 64'(db_width);
          ev_b[n_ev] = 64'(db_data); n_ev++;
        end
      end else db_cnt++;
    end
  end

  // response / interrupt monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq) irq_cnt++;
      if (rsp_valid && n_ev < 32) begin
        ev_kind[n_ev] = K_RSP; ev_a[n_ev] = 64'({rsp_err, rsp_seq, rsp_id});
        ev_b[n_ev] = 64'(irq); n_ev++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic ev_is(input int k, input int kind, input logic [63:0] a,
                       input string req);
    chk(n_ev > k && ev_kind[k] == kind, req, $sformatf("event %0d kind", k),
        64'(ev_kind[k]), 64'(kind));
    chk(ev_a[k] == a, req, $sformatf("event %0d fields", k), ev_a[k], a);
  endtask

  function automatic logic [31:0] mk_sem(input bit on, input bit fh, input bit fd,
      input bit pre, input logic [2:0] op, input logic [4:0] idx,
      input logic [11:0] val);
    return {on, fh, fd, 2'b00, op, 1'b0, pre, 1'b0, idx, 4'h0, val};
  endfunction

  function automatic logic [63:0] rsp_key(input bit err, input logic [15:0] seq,
                                          input logic [15:0] id);
    return 64'({err, seq, id});
  endfunction

  task automatic issue(input logic [7:0] cmd, input logic [15:0] id,
                       input logic [15:0] seq, input logic [7:0] attr,
                       input logic [31:0] dbd, input logic [NS*32-1:0] sems);
    n_ev = 0; irq_cnt = 0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_cmd = cmd; req_id = id; req_seq = seq;
    req_db_attr = attr; req_db_data = dbd; req_sem = sems;
    @(negedge clk);
    req_valid = 1'b0; req_sem = '0;
  endtask

  task automatic wait_idle();
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R11", "ready after reset", 64'(req_ready), 1);
    chk({sem_req, dma_start, db_req, rsp_valid, irq} == 5'b0, "R11",
        "outputs quiet after reset",
        64'({sem_req, dma_start, db_req, rsp_valid, irq}), 0);
  endtask

  task automatic t_bulk_h2d();
    req_src = 64'h1111_2222_3333_4440; req_dst = 64'h0000_0000_8000_0000;
    req_len = 32'hFFFF_FFFF;
    issue(8'h19, 16'h00A1, 16'h0005, 8'h00, 32'h0, '0);
    wait_idle();
    chk(n_ev == 2, "R1", "event count bulk h2d", 64'(n_ev), 2);
    ev_is(0, K_DMA, 64'({2'd1, 1'b1}), "R1");
    chk(ev_b[0] == 64'h1111_2222_3333_4440, "R3", "src", ev_b[0], 64'h1111_2222_3333_4440);
    chk(last_dst == 64'h8000_0000, "R3", "dst", last_dst, 64'h8000_0000);
    chk(last_len == 64'hFFFF_FFFF, "R3", "len at max", last_len, 64'hFFFF_FFFF);
    ev_is(1, K_RSP, rsp_key(1'b0, 16'h0005, 16'h00A1), "R4");
    chk(irq_cnt == 0, "R5", "no irq without bit7", 64'(irq_cnt), 0);
  endtask

  task automatic t_list_d2h();
    req_src = 64'h0000_0000_0000_7700;
    issue(8'h02, 16'h00B2, 16'h7777, 8'h00, 32'h0, '0);
    wait_idle();
    ev_is(0, K_DMA, 64'({2'd2, 1'b0}), "R3");
    chk(ev_b[0] == 64'h7700, "R3", "list address on src", ev_b[0], 64'h7700);
    chk(n_ev == 1, "R4", "no response when bit4 clear", 64'(n_ev), 1);
  endtask

  task automatic t_order();
    logic [NS*32-1:0] s;
    s = {mk_sem(1, 0, 0, 0, 3'd0, 5'd9, 12'd1),     // slot3 no-op: skipped
         mk_sem(1, 0, 0, 0, 3'd3, 5'd1, 12'd2),     // slot2 post dec
         mk_sem(1, 0, 0, 1, 3'd5, 5'd7, 12'd9),     // slot1 presync wait-ge
         mk_sem(1, 0, 0, 0, 3'd2, 5'd3, 12'd5)};    // slot0 post inc
    issue(8'h19, 16'h00C3, 16'h0001, 8'h81, 32'hABCD_1234, s);
    wait_idle();
    chk(n_ev == 6, "R7", "event count ordered request", 64'(n_ev), 6);
    ev_is(0, K_SEM, 64'({3'd5, 5'd7, 12'd9}), "R6");
    ev_is(1, K_DMA, 64'({2'd1, 1'b1}), "R6");
    ev_is(2, K_SEM, 64'({3'd2, 5'd3, 12'd5}), "R7");
    ev_is(3, K_SEM, 64'({3'd3, 5'd1, 12'd2}), "R7");
    ev_is(4, K_DB, 64'(2'd1), "R9");
    chk(ev_b[4] == 64'h1234, "R9", "16-bit doorbell data", ev_b[4], 64'h1234);
    ev_is(5, K_RSP, rsp_key(1'b0, 16'h0001, 16'h00C3), "R9");
  endtask

  task automatic t_two_pre();
    logic [NS*32-1:0] s;
    s = '0;
    s[31:0]  = mk_sem(1, 0, 0, 1, 3'd1, 5'd2, 12'd3);
    s[95:64] = mk_sem(1, 0, 0, 1, 3'd2, 5'd4, 12'd1);
    issue(8'h09, 16'h00D4, 16'h0002, 8'h80, 32'h5, s);
    wait_idle();
    chk(n_ev == 1, "R6", "two presync: only response", 64'(n_ev), 1);
    ev_is(0, K_RSP, rsp_key(1'b1, 16'h0002, 16'h00D4), "R6");
  endtask

  task automatic t_bad_dir();
    logic [NS*32-1:0] s;
    s = '0;
    s[63:32] = mk_sem(1, 0, 0, 0, 3'd2, 5'd6, 12'd1);
    issue(8'h0B, 16'h00E5, 16'h0003, 8'h80, 32'h9, s);
    wait_idle();
    chk(n_ev == 1, "R2", "illegal dir: only response", 64'(n_ev), 1);
    ev_is(0, K_RSP, rsp_key(1'b1, 16'h0003, 16'h00E5), "R2");
  endtask

  task automatic t_dir_none();
    logic [NS*32-1:0] s;
    s = '0;
    s[31:0]   = mk_sem(1, 0, 0, 0, 3'd1, 5'd10, 12'd44);
    s[127:96] = mk_sem(1, 0, 0, 1, 3'd6, 5'd11, 12'd0);
    issue(8'h10, 16'h00F6, 16'h0004, 8'h00, 32'h0, s);
    wait_idle();
    chk(n_ev == 3, "R1", "dir 0: no transfer", 64'(n_ev), 3);
    ev_is(0, K_SEM, 64'({3'd6, 5'd11, 12'd0}), "R1");
    ev_is(1, K_SEM, 64'({3'd1, 5'd10, 12'd44}), "R1");
    ev_is(2, K_RSP, rsp_key(1'b0, 16'h0004, 16'h00F6), "R4");
  endtask

  task automatic t_fence();
    logic [NS*32-1:0] s;
    s = '0;
    s[31:0] = mk_sem(1, 1, 0, 0, 3'd0, 5'd0, 12'd0);
    h2d_busy = 1'b1;
    issue(8'h11, 16'h0107, 16'h0006, 8'h00, 32'h0, s);
    repeat (12) @(negedge clk);
    chk(n_ev == 0, "R8", "held while h2d busy", 64'(n_ev), 0);
    chk(req_ready == 1'b0, "R11", "not ready in flight", 64'(req_ready), 0);
    h2d_busy = 1'b0;
    wait_idle();
    ev_is(0, K_DMA, 64'({2'd1, 1'b0}), "R8");
    // unrequested fence line high must not delay
    d2h_busy = 1'b1;
    issue(8'h11, 16'h0108, 16'h0006, 8'h00, 32'h0, s);
    repeat (6) @(negedge clk);
    chk(n_ev >= 1 && ev_kind[0] == K_DMA, "R8", "unrequested fence ignored",
        64'(n_ev), 1);
    wait_idle();
    d2h_busy = 1'b0;
  endtask

  task automatic t_irq();
    force_irq_en = 1'b1;
    issue(8'h91, 16'h0209, 16'h0007, 8'h00, 32'h0, '0);
    wait_idle();
    ev_is(1, K_RSP, rsp_key(1'b0, 16'h0007, 16'h0209), "R5");
    chk(ev_b[1] == 64'd1, "R5", "irq in response cycle", ev_b[1], 1);
    chk(irq_cnt == 1, "R5", "single irq pulse", 64'(irq_cnt), 1);
    force_irq_en = 1'b0;
    issue(8'h81, 16'h020A, 16'h0008, 8'h00, 32'h0, '0);
    wait_idle();
    chk(irq_cnt == 0, "R5", "irq blocked when disabled", 64'(irq_cnt), 0);
  endtask

  task automatic t_db_widths();
    issue(8'h00, 16'h0301, 16'h0009, 8'h82, 32'hCAFE_F00D, '0);
    wait_idle();
    ev_is(0, K_DB, 64'(2'd2), "R9");
    chk(ev_b[0] == 64'h0D, "R9", "8-bit doorbell data", ev_b[0], 64'h0D);
    issue(8'h00, 16'h0302, 16'h0009, 8'h80, 32'hCAFE_F00D, '0);
    wait_idle();
    chk(ev_b[0] == 64'hCAFE_F00D, "R9", "32-bit doorbell data", ev_b[0], 64'hCAFE_F00D);
    issue(8'h10, 16'h0303, 16'h0009, 8'h83, 32'hCAFE_F00D, '0);
    wait_idle();
    chk(n_ev == 1 && ev_kind[0] == K_RSP, "R9", "reserved width skips doorbell",
        64'(n_ev), 1);
  endtask

  task automatic t_seq_neutral();
    issue(8'h12, 16'h0400, 16'hFFFF, 8'h00, 32'h0, '0);
    wait_idle();
    chk(n_ev == 2 && ev_kind[0] == K_DMA, "R10", "seq id no effect", 64'(n_ev), 2);
    ev_is(1, K_RSP, rsp_key(1'b0, 16'hFFFF, 16'h0400), "R10");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bulk_h2d();
    t_list_d2h();
    t_order();
    t_two_pre();
    t_bad_dir();
    t_dir_none();
    t_fence();
    t_irq();
    t_db_widths();
    t_seq_neutral();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule